// File: doc/BRIEF.md
# Interrupt Flag Aggregation Controller

This block holds the request flags for a classic eight-bit microcontroller's interrupt sources and turns them into a single prioritized request for the CPU's vectoring logic. Twelve sources are served. Several sources are wired-OR groups of individual flags, and each source has its own rule for whether its flags clear automatically when the CPU acknowledges its vector. Two external, active-low pins can each be set for falling-edge or level detection.

Peripherals raise flags with one-cycle event pulses. Software sets or clears any flag through per-flag strobes, and reads the current flag vector back. Each source has an enable bit and a two-bit priority level made from a high bit and a low bit. Each of the four levels also has a disable bit that blocks every source at that level. The block presents the index of the winning source together with a request line.

Top module: `irq_agg_top`

Flag layout (flag index → source): 0 ext0; 1 timer0; 2 ext1; 3 timer1; 4–5 serial (rx, tx); 6–7 timer2 (overflow, external); 8–10 SPI; 11–18 general-purpose; 19–20 comparators; 21 conversion done; 22–25 compare/capture; 26 two-wire. Source indices 0..11 follow the same order.

## Requirements
- R1: After reset every flag is 0, `irqReq` is 0 and `irqIdx` is 0.
- R2: With `extEdgeMode[k]`=1, a high-to-low transition on `extPinN[k]` sets that pin's flag on the third rising clock edge after the pin changes. A pin held low sets it only once, so the flag stays clear after an acknowledge.
- R3: With `extEdgeMode[k]`=0, the pin's flag equals the inverted pin delayed by three clocks. Acknowledges and software writes do not change it.
- R4: An acknowledge clears the flag of timer0 (source 1), timer1 (source 3) and conversion done (source 9). It also clears the flag of an external source that is in edge mode.
- R5: Serial, timer2, SPI, general-purpose, comparator, compare/capture and two-wire flags are never cleared by an acknowledge. A group source requests while any one of its flags is set.
- R6: A `swSet` bit sets its flag on the next clock edge and creates a pending request. A `swClr` bit clears its flag and cancels the request.
- R7: If a hardware event and a clear (software or acknowledge) hit the same flag in the same cycle, the flag ends up set. A general-purpose source that is held asserted therefore cannot be cleared by software.
- R8: An acknowledge changes only the flags of the source whose index is given on `vecAckIdx`.
- R9: Among eligible sources, the one with the highest level {`prioHi`,`prioLo`} wins. Equal levels go to the lowest source index.
- R10: A source is not eligible while its `srcEnable` bit is 0 or while `levelDisable` is set for its level. Its flags are kept.
- R11: With no eligible source, `irqReq` is 0 and `irqIdx` is 0. The request and index follow the flags and the configuration inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPinN | input | 2 | External interrupt pins, active low, asynchronous |
| extEdgeMode | input | 2 | 1 = falling-edge detection, 0 = level detection, per pin |
| hwEvent | input | 27 | One-cycle peripheral set pulses per flag (bits 0 and 2 unused) |
| swSet | input | 27 | Software set strobes per flag |
| swClr | input | 27 | Software clear strobes per flag |
| vecAck | input | 1 | One-cycle vector acknowledge strobe |
| vecAckIdx | input | 4 | Source index being acknowledged |
| srcEnable | input | 12 | Per-source enable |
| prioHi | input | 12 | Per-source high priority bit |
| prioLo | input | 12 | Per-source low priority bit |
| levelDisable | input | 4 | Blocks all sources of level n when bit n is set |
| irqReq | output | 1 | A source is eligible |
| irqIdx | output | 4 | Winning source index |
| flagState | output | 27 | Current flag vector for software readback |

## Verification
Two functions can land on the same flag in one clock: a peripheral raising a flag, and a clear that comes either from the acknowledge or from a software write. The bench provokes both. It sends a timer1 event in the same cycle as timer1's own acknowledge, and it sends a general-purpose event in the same cycle as a software clear of that flag. In both cases it checks, after the edge, that the flag reads back as set and that the source still wins arbitration. A related pairing, an acknowledge arriving while another auto-clear source is pending, is judged by checking that only the acknowledged source's flag drops.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int NUM_SRC   = 12;
  localparam int NUM_FLAGS = 27;
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int NUM_LVL   = 4;
  localparam int EXT0_SRC  = 0;
  localparam int EXT1_SRC  = 2;

  // number of flags OR-ed into one source request
  function automatic int srcWidth(input int s);
    case (s)
      4, 5, 8: return 2;
      6:       return 3;
      7:       return 8;
      10:      return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int srcBase(input int s);
    int b;
    b = 0;
    for (int i = 0; i < s; i++) b += srcWidth(i);
    return b;
  endfunction

  function automatic int flagOwner(input int f);
    for (int s = 0; s < NUM_SRC; s++)
      if (f >= srcBase(s) && f < srcBase(s) + srcWidth(s)) return s;
    return 0;
  endfunction

  // sources whose flags always drop on their own acknowledge
  function automatic bit autoClear(input int s);
    return (s == 1) || (s == 3) || (s == 9);
  endfunction

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setMask;
    logic [NUM_FLAGS-1:0] clrMask;
  } flagStrobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] swSet,
  input  logic [NUM_FLAGS-1:0] swClr,
  input  logic                 vecAck,
  input  logic [SRC_W-1:0]     vecAckIdx,
  input  logic [1:0]           extEdgeMode,
  output flagStrobe_t          strobe
);

  logic [NUM_FLAGS-1:0] ackClr;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_ack
    localparam int OWN = flagOwner(f);
    logic hit;
    assign hit = vecAck && (vecAckIdx == SRC_W'(OWN));
    if (OWN == EXT0_SRC) begin : g_e0
      assign ackClr[f] = hit && extEdgeMode[0];
    end else if (OWN == EXT1_SRC) begin : g_e1
      assign ackClr[f] = hit && extEdgeMode[1];
    end else if (autoClear(OWN)) begin : g_auto
      assign ackClr[f] = hit;
    end else begin : g_keep
      assign ackClr[f] = 1'b0;
    end
  end

  always_comb begin
    strobe.setMask = swSet;
    strobe.clrMask = swClr | ackClr;
  end

  // R8: acknowledge never produces a clear outside the addressed source
  always_comb begin
    for (int f = 0; f < NUM_FLAGS; f++)
      if (ackClr[f]) assert_ack_scope_R8: assert (vecAckIdx == SRC_W'(flagOwner(f)));
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           extPinN,
  input  logic [1:0]           extEdgeMode,
  input  logic [NUM_FLAGS-1:0] hwEvent,
  input  flagStrobe_t          strobe,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_SRC-1:0]   srcPending
);

  localparam int EXT0_BIT = srcBase(EXT0_SRC);
  localparam int EXT1_BIT = srcBase(EXT1_SRC);

  logic [1:0] extActive;
  logic [1:0] extFall;

  for (genvar k = 0; k < 2; k++) begin : g_sync
    logic [SYNC_DEPTH:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_DEPTH-1:0], extPinN[k]};
    end
    assign extActive[k] = ~chain[SYNC_DEPTH-1];
    assign extFall[k]   = chain[SYNC_DEPTH] & ~chain[SYNC_DEPTH-1];
  end

  logic [NUM_FLAGS-1:0] hwSet;
  logic unusedExtHw;

  always_comb begin
    hwSet           = hwEvent;
    hwSet[EXT0_BIT] = extFall[0];
    hwSet[EXT1_BIT] = extFall[1];
  end
  assign unusedExtHw = hwEvent[EXT0_BIT] ^ hwEvent[EXT1_BIT];

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    localparam int OWN = flagOwner(f);
    logic setNow;
    assign setNow = hwSet[f] | strobe.setMask[f];
    if (OWN == EXT0_SRC || OWN == EXT1_SRC) begin : g_ext
      localparam int K = (OWN == EXT0_SRC) ? 0 : 1;
      always_ff @(posedge clk) begin
        if (!rstN)                flags[f] <= 1'b0;
        else if (!extEdgeMode[K]) flags[f] <= extActive[K];
        else                      flags[f] <= setNow | (flags[f] & ~strobe.clrMask[f]);
      end

      assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
        (extEdgeMode[K] && extFall[K]) |=> flags[f]);

      assert_level_tracks_R3: assert property (@(posedge clk) disable iff (!rstN)
        !extEdgeMode[K] |=> (flags[f] == $past(extActive[K])));
    end else begin : g_int
      always_ff @(posedge clk) begin
        if (!rstN) flags[f] <= 1'b0;
        else       flags[f] <= setNow | (flags[f] & ~strobe.clrMask[f]);
      end

      assert_hw_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
        hwEvent[f] |=> flags[f]);

      assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.clrMask[f] && !setNow) |=> !flags[f]);
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_grp
    assign srcPending[s] = |flags[srcBase(s) +: srcWidth(s)];
  end

endmodule

// File: rtl/irq_agg_arbiter.sv
module irq_agg_arbiter
  import irq_agg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcPending,
  input  logic [NUM_SRC-1:0]   srcEnable,
  input  logic [NUM_SRC-1:0]   prioHi,
  input  logic [NUM_SRC-1:0]   prioLo,
  input  logic [NUM_LVL-1:0]   levelDisable,
  output logic                 irqReq,
  output logic [SRC_W-1:0]     irqIdx
);

  logic [NUM_SRC-1:0] eligible;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_elig
    assign eligible[s] = srcPending[s] & srcEnable[s] & ~levelDisable[{prioHi[s], prioLo[s]}];
  end

  logic [1:0] bestLvl;

  always_comb begin
    irqReq  = 1'b0;
    irqIdx  = '0;
    bestLvl = 2'd0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (eligible[s] && (!irqReq || {prioHi[s], prioLo[s]} > bestLvl)) begin
        irqReq  = 1'b1;
        irqIdx  = SRC_W'(s);
        bestLvl = {prioHi[s], prioLo[s]};
      end
    end
  end

  assert_grant_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (srcPending[irqIdx] && srcEnable[irqIdx]
                && !levelDisable[{prioHi[irqIdx], prioLo[irqIdx]}]));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (srcPending & srcEnable) == '0 |-> (!irqReq && irqIdx == '0));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    assert_level_max_R9: assert property (@(posedge clk) disable iff (!rstN)
      eligible[s] |-> ({prioHi[s], prioLo[s]} < {prioHi[irqIdx], prioLo[irqIdx]}
                       || ({prioHi[s], prioLo[s]} == {prioHi[irqIdx], prioLo[irqIdx]}
                           && SRC_W'(s) >= irqIdx)));
  end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           extPinN,
  input  logic [1:0]           extEdgeMode,
  input  logic [NUM_FLAGS-1:0] hwEvent,
  input  logic [NUM_FLAGS-1:0] swSet,
  input  logic [NUM_FLAGS-1:0] swClr,
  input  logic                 vecAck,
  input  logic [SRC_W-1:0]     vecAckIdx,
  input  logic [NUM_SRC-1:0]   srcEnable,
  input  logic [NUM_SRC-1:0]   prioHi,
  input  logic [NUM_SRC-1:0]   prioLo,
  input  logic [NUM_LVL-1:0]   levelDisable,
  output logic                 irqReq,
  output logic [SRC_W-1:0]     irqIdx,
  output logic [NUM_FLAGS-1:0] flagState
);

  flagStrobe_t        strobe;
  logic [NUM_SRC-1:0] srcPending;

  irq_agg_ctrl u_ctrl (
    .swSet       (swSet),
    .swClr       (swClr),
    .vecAck      (vecAck),
    .vecAckIdx   (vecAckIdx),
    .extEdgeMode (extEdgeMode),
    .strobe      (strobe)
  );

  irq_agg_datapath #(.SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .extPinN     (extPinN),
    .extEdgeMode (extEdgeMode),
    .hwEvent     (hwEvent),
    .strobe      (strobe),
    .flags       (flagState),
    .srcPending  (srcPending)
  );

  irq_agg_arbiter u_arb (
    .clk          (clk),
    .rstN         (rstN),
    .srcPending   (srcPending),
    .srcEnable    (srcEnable),
    .prioHi       (prioHi),
    .prioLo       (prioLo),
    .levelDisable (levelDisable),
    .irqReq       (irqReq),
    .irqIdx       (irqIdx)
  );

  // R4: timer0 flag drops after its own acknowledge when nothing re-sets it
  assert_auto_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck && vecAckIdx == SRC_W'(1) && !hwEvent[1] && !swSet[1]) |=> !flagState[1]);

  // R5: serial flags survive their acknowledge
  assert_group_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck && vecAckIdx == SRC_W'(4) && flagState[4] && !swClr[4]) |=> flagState[4]);

endmodule

// File: tb/irq_agg_top_tb.sv
`timescale 1ns/1ps
module irq_agg_top_tb;

  localparam int NF = 27;
  localparam int NS = 12;

  function automatic logic [NF-1:0] fb(input int i);
    return NF'(1) << i;
  endfunction

  typedef struct packed {
    logic [NF-1:0] hw;
    logic [NF-1:0] ss;
    logic [NF-1:0] sc;
    logic          ack;
    logic [3:0]    ackIdx;
    logic          expReq;
    logic [3:0]    expIdx;
    logic [NF-1:0] expFlags;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{'0,       fb(1),  '0,               1'b0, 4'd0,  1'b1, 4'd1,  fb(1)},                  // R6 sw set
    '{fb(21),   '0,     '0,               1'b0, 4'd0,  1'b1, 4'd1,  fb(1)|fb(21)},
    '{'0,       '0,     '0,               1'b1, 4'd1,  1'b1, 4'd9,  fb(21)},                 // R4/R8
    '{'0,       '0,     '0,               1'b1, 4'd9,  1'b0, 4'd0,  '0},                     // R4 conv
    '{fb(5),    '0,     '0,               1'b0, 4'd0,  1'b1, 4'd4,  fb(5)},                  // R5 serial
    '{'0,       '0,     '0,               1'b1, 4'd4,  1'b1, 4'd4,  fb(5)},                  // R5 keep
    '{'0,       '0,     fb(5),            1'b0, 4'd0,  1'b0, 4'd0,  '0},                     // R6 sw clr
    '{fb(12)|fb(26), '0, '0,              1'b0, 4'd0,  1'b1, 4'd7,  fb(12)|fb(26)},          // R5 gp
    '{fb(3),    '0,     '0,               1'b1, 4'd7,  1'b1, 4'd3,  fb(3)|fb(12)|fb(26)},
    '{fb(3),    '0,     '0,               1'b1, 4'd3,  1'b1, 4'd3,  fb(3)|fb(12)|fb(26)},    // R7 ack
    '{'0,       '0,     '0,               1'b1, 4'd3,  1'b1, 4'd7,  fb(12)|fb(26)},          // R4 tmr1
    '{fb(12),   '0,     fb(12),           1'b0, 4'd0,  1'b1, 4'd7,  fb(12)|fb(26)},          // R7 sw
    '{'0,       '0,     fb(12)|fb(26),    1'b0, 4'd0,  1'b0, 4'd0,  '0},
    '{'0,       fb(23)|fb(9), '0,         1'b0, 4'd0,  1'b1, 4'd6,  fb(23)|fb(9)},           // R5 spi
    '{'0,       '0,     fb(23),           1'b1, 4'd6,  1'b1, 4'd6,  fb(9)},                  // R5 ack
    '{'0,       '0,     fb(9),            1'b0, 4'd0,  1'b0, 4'd0,  '0}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    extPinN;
  logic [1:0]    extEdgeMode;
  logic [NF-1:0] hwEvent, swSet, swClr;
  logic          vecAck;
  logic [3:0]    vecAckIdx;
  logic [NS-1:0] srcEnable, prioHi, prioLo;
  logic [3:0]    levelDisable;
  logic          irqReq;
  logic [3:0]    irqIdx;
  logic [NF-1:0] flagState;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg_top u_dut (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .extEdgeMode(extEdgeMode),
    .hwEvent(hwEvent), .swSet(swSet), .swClr(swClr), .vecAck(vecAck),
    .vecAckIdx(vecAckIdx), .srcEnable(srcEnable), .prioHi(prioHi), .prioLo(prioLo),
    .levelDisable(levelDisable), .irqReq(irqReq), .irqIdx(irqIdx), .flagState(flagState)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input logic eReq, input logic [3:0] eIdx, input logic [NF-1:0] eFl);
    chk(irqReq == eReq, req, 32'(irqReq), 32'(eReq));
    chk(irqIdx == eIdx, req, 32'(irqIdx), 32'(eIdx));
    chk(flagState == eFl, req, 32'(flagState), 32'(eFl));
  endtask

  task automatic idleIn();
    hwEvent = '0; swSet = '0; swClr = '0; vecAck = 1'b0; vecAckIdx = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; extPinN = 2'b11; extEdgeMode = 2'b11; idleIn();
    srcEnable = '1; prioHi = '0; prioLo = '0; levelDisable = '0;
    repeat (3) @(negedge clk);
    chkOut("R1 reset", 1'b0, 4'd0, '0);
    rstN = 1'b1;
    @(negedge clk);
    chkOut("R1 after reset", 1'b0, 4'd0, '0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      hwEvent = VEC[v].hw; swSet = VEC[v].ss; swClr = VEC[v].sc;
      vecAck = VEC[v].ack; vecAckIdx = VEC[v].ackIdx;
      @(negedge clk);
      idleIn();
      chkOut($sformatf("R4-7 vector %0d", v), VEC[v].expReq, VEC[v].expIdx, VEC[v].expFlags);
    end

    // R2 edge detection on pin 0
    @(negedge clk); extPinN[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(flagState == '0, "R2 not yet", 32'(flagState), 32'h0);
    @(negedge clk);
    chkOut("R2 edge set", 1'b1, 4'd0, fb(0));
    vecAck = 1'b1; vecAckIdx = 4'd0;
    @(negedge clk); idleIn();
    chkOut("R4 edge ack", 1'b0, 4'd0, '0);
    repeat (3) @(negedge clk);
    chk(flagState == '0, "R2 held low once", 32'(flagState), 32'h0);
    extPinN[0] = 1'b1;
    repeat (4) @(negedge clk);
    chk(flagState == '0, "R2 rising ignored", 32'(flagState), 32'h0);

    // R3 level mode on pin 1
    extEdgeMode[1] = 1'b0;
    @(negedge clk); extPinN[1] = 1'b0;
    repeat (4) @(negedge clk);
    chkOut("R3 level active", 1'b1, 4'd2, fb(2));
    vecAck = 1'b1; vecAckIdx = 4'd2; swClr = fb(2);
    @(negedge clk); idleIn();
    chkOut("R3 ack/clr ignored", 1'b1, 4'd2, fb(2));
    extPinN[1] = 1'b1;
    repeat (4) @(negedge clk);
    chkOut("R3 level release", 1'b0, 4'd0, '0);
    extEdgeMode[1] = 1'b1;
    @(negedge clk);

    // R9/R10/R11 priority and masking
    swSet = fb(1) | fb(26) | fb(19);
    @(negedge clk); idleIn();
    chkOut("R9 tie lowest index", 1'b1, 4'd1, fb(1) | fb(26) | fb(19));
    prioHi[11] = 1'b1; #1;
    chk(irqIdx == 4'd11, "R9 level 2 wins", 32'(irqIdx), 32'd11);
    prioHi[8] = 1'b1; prioLo[8] = 1'b1; #1;
    chk(irqIdx == 4'd8, "R9 level 3 wins", 32'(irqIdx), 32'd8);
    levelDisable[3] = 1'b1; #1;
    chk(irqIdx == 4'd11, "R10 level disabled", 32'(irqIdx), 32'd11);
    srcEnable[11] = 1'b0; #1;
    chk(irqIdx == 4'd1, "R10 source disabled", 32'(irqIdx), 32'd1);
    levelDisable[0] = 1'b1; #1;
    chkOut("R11 nothing eligible", 1'b0, 4'd0, fb(1) | fb(26) | fb(19));
    levelDisable = '0; srcEnable = '1; prioHi = '0; prioLo = '0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule